// File: doc/BRIEF.md
# Arbitrary Track Jump Sequencer

This block moves an optical pickup across a chosen number of tracks, inward or outward, in three timed phases. During the first phase, it pushes the actuator and counts tracks on the tracking-error comparator. During the second phase, it reverses the push until the tracking-error comparator slows down. During the third phase, it brakes with boosted tracking gain until subcode data becomes readable. The direction drive pair, the tracking-off line and the gain boost come from registers. The block counts time with a one-microsecond strobe.

A host first writes a mode byte. The mode byte selects how much of the jump is spent accelerating, and how long a tracking-error half-period must last before the block judges the pickup to be nearly stopped. A start command then gives the direction and the track count. The tracking-error, mirror-detect and subcode-ready inputs are asynchronous. Each passes through a two-flop synchroniser before any edge is taken from it.

Top module: `trackjump_seq`

## Requirements
- R1: After a synchronous reset, `busy`, `jp_plus`, `jp_minus`, `toff` and `gain_boost` are all low, and the stored mode byte is 0x00.
- R2: Command code 0x48 stores `cmd_data` as the mode byte. Code 0x77 starts an inward jump and code 0x7F starts an outward jump, with the track count N taken from `cmd_data`. A start with N below 16, or with any other code, leaves the block idle.
- R3: The acceleration phase ends on the T-th rising edge of the tracking-error input, where T = (N*k + 8) >> 4. The multiplier k is set by mode bits [5:4]: 00 gives 8, 01 gives 9, 10 gives 10, and 11 gives 8.
- R4: The deceleration phase ends once the time since the last tracking-error edge (of either polarity) exceeds a threshold. The threshold in microseconds is 123*m[3] + 62*m[2] + 32*m[1] + 17*m[0], where m is mode bits [3:0]. The value 0000 gives 306.
- R5: The deceleration phase also ends once it has lasted as many microseconds as the acceleration phase did, even while the tracking-error input keeps toggling.
- R6: On an outward jump, `jp_plus` is high during acceleration and `jp_minus` is high during deceleration. On an inward jump the roles swap. The two outputs are never high together, and both are low outside these two phases.
- R7: `gain_boost` is high only during braking. During braking, `toff` takes the synchronised mirror-detect level at each tracking-error edge and holds it between edges. Outside braking, `toff` is low.
- R8: Braking ends on a rising edge of `wrq_in`, or after BRAKE_US microseconds without one. `busy` then falls.
- R9: While a jump is in progress, start commands are ignored. A mode byte written during a jump only takes effect at the next start, because the target and threshold are captured when the jump starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| us_tick | input | 1 | One-cycle strobe every microsecond |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 8 | Command code |
| cmd_data | input | 8 | Mode byte or track count |
| tes_in | input | 1 | Tracking-error comparator, asynchronous |
| hfl_in | input | 1 | Mirror detect, high over mirror, asynchronous |
| wrq_in | input | 1 | Subcode-ready, asynchronous |
| jp_plus | output | 1 | Positive actuator drive |
| jp_minus | output | 1 | Negative actuator drive |
| toff | output | 1 | Tracking-off |
| gain_boost | output | 1 | Tracking gain boost |
| busy | output | 1 | Jump in progress |

## Verification
During braking, a tracking-error edge and a subcode-ready rising edge can reach the sequencer in the same cycle. The edge would capture a new `toff` level, while the ready edge ends the jump. The bench provokes this by changing both inputs on the same clock with the mirror-detect input high, so both pass through identical synchronisers and arrive together. The exit must win: afterwards `busy` is low and `toff` is low rather than holding the captured mirror level.

// File: rtl/tj_pkg.sv
package tj_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_ACC, PH_DEC, PH_BRK} tj_phase_e;
  localparam logic [7:0] CODE_MODE = 8'h48;
  localparam logic [7:0] CODE_IN   = 8'h77;
  localparam logic [7:0] CODE_OUT  = 8'h7F;
  localparam int MIN_TRACKS = 16;
  localparam int THR_DEFAULT = 306;
  localparam int THR_W3 = 123;
  localparam int THR_W2 = 62;
  localparam int THR_W1 = 32;
  localparam int THR_W0 = 17;
endpackage

// File: rtl/tj_sync.sv
module tj_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q, stab_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= async_i;
      stab_q <= meta_q;
    end
  end
  assign sync_o = stab_q;
endmodule

// File: rtl/tj_halfper.sv
module tj_halfper #(
  parameter int HP_W = 9
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            us_tick,
  input  logic            tes_lvl,
  output logic [HP_W-1:0] cnt_o
);
  logic            tes_d;
  logic            tes_edge;
  logic [HP_W-1:0] cnt_q;

  assign tes_edge = tes_lvl ^ tes_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      tes_d <= 1'b0;
      cnt_q <= '0;
    end else begin
      tes_d <= tes_lvl;
      if (tes_edge)
        cnt_q <= '0;
      else if (us_tick && cnt_q != '1)
        cnt_q <= cnt_q + 1'b1;
    end
  end
  assign cnt_o = cnt_q;

  // R4: the elapsed time only falls back when an edge was seen
  assert_hp_monotonic_R4: assert property (@(posedge clk) disable iff (rst)
    !$past(tes_edge) |-> cnt_q >= $past(cnt_q));
endmodule

// File: rtl/tj_ctrl.sv
module tj_ctrl
  import tj_pkg::*;
#(
  parameter int N_W      = 8,
  parameter int TIME_W   = 16,
  parameter int HP_W     = 9,
  parameter int BRAKE_US = 60000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            us_tick,
  input  logic            cmd_valid,
  input  logic [7:0]      cmd_code,
  input  logic [N_W-1:0]  cmd_data,
  input  logic            tes_lvl,
  input  logic            hfl_lvl,
  input  logic            wrq_lvl,
  input  logic [HP_W-1:0] hp_cnt,
  output logic            jp_plus,
  output logic            jp_minus,
  output logic            toff,
  output logic            gain_boost,
  output logic            busy
);
  localparam int BRK_W  = $clog2(BRAKE_US + 1);
  localparam int PROD_W = N_W + 5;

  tj_phase_e       phase;
  logic [7:0]      mode_q;
  logic            dir_out;
  logic [N_W-1:0]  target_q, tcnt_q;
  logic [TIME_W-1:0] a_t, b_t;
  logic [BRK_W-1:0]  c_t;
  logic [HP_W-1:0] thr_q;
  logic            toff_q, jpp_q, jpm_q, gain_q, busy_q;
  logic            tes_d, wrq_d, tes_rise, tes_edge, wrq_rise;
  logic            start_cmd, start_ok, mode_wr;
  logic [3:0]      kfac;
  logic [PROD_W-1:0] prod;
  logic [N_W-1:0]  target_calc;
  logic [HP_W-1:0] thr_calc;
  logic            hp_over, guard_hit, brk_timeout;

  assign tes_rise = tes_lvl & ~tes_d;
  assign tes_edge = tes_lvl ^ tes_d;
  assign wrq_rise = wrq_lvl & ~wrq_d;

  assign mode_wr   = cmd_valid && (cmd_code == CODE_MODE);
  assign start_cmd = cmd_valid && (cmd_code == CODE_IN || cmd_code == CODE_OUT);
  assign start_ok  = start_cmd && (cmd_data >= N_W'(MIN_TRACKS));

  always_comb begin
    unique case (mode_q[5:4])
      2'b01:   kfac = 4'd9;
      2'b10:   kfac = 4'd10;
      default: kfac = 4'd8;
    endcase
    prod        = PROD_W'(cmd_data) * PROD_W'(kfac) + PROD_W'(8);
    target_calc = prod[N_W+3:4];
    if (mode_q[3:0] == 4'd0) begin
      thr_calc = HP_W'(THR_DEFAULT);
    end else begin
      thr_calc = '0;
      if (mode_q[3]) thr_calc = thr_calc + HP_W'(THR_W3);
      if (mode_q[2]) thr_calc = thr_calc + HP_W'(THR_W2);
      if (mode_q[1]) thr_calc = thr_calc + HP_W'(THR_W1);
      if (mode_q[0]) thr_calc = thr_calc + HP_W'(THR_W0);
    end
  end

  assign hp_over     = hp_cnt > thr_q;
  assign guard_hit   = b_t >= a_t;
  assign brk_timeout = c_t >= BRK_W'(BRAKE_US);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      mode_q   <= '0;
      dir_out  <= 1'b0;
      target_q <= '0;
      tcnt_q   <= '0;
      a_t      <= '0;
      b_t      <= '0;
      c_t      <= '0;
      thr_q    <= HP_W'(THR_DEFAULT);
      toff_q   <= 1'b0;
      tes_d    <= 1'b0;
      wrq_d    <= 1'b0;
    end else begin
      tes_d <= tes_lvl;
      wrq_d <= wrq_lvl;
      if (mode_wr) mode_q <= cmd_data;
      unique case (phase)
        PH_IDLE: begin
          toff_q <= 1'b0;
          if (start_ok) begin
            phase    <= PH_ACC;
            dir_out  <= (cmd_code == CODE_OUT);
            target_q <= target_calc;
            thr_q    <= thr_calc;
            tcnt_q   <= '0;
            a_t      <= '0;
          end
        end
        PH_ACC: begin
          if (us_tick && a_t != '1) a_t <= a_t + 1'b1;
          if (tes_rise) begin
            if (tcnt_q + 1'b1 == target_q) begin
              phase <= PH_DEC;
              b_t   <= '0;
            end else begin
              tcnt_q <= tcnt_q + 1'b1;
            end
          end
        end
        PH_DEC: begin
          if (us_tick && b_t != '1) b_t <= b_t + 1'b1;
          if (hp_over || guard_hit) begin
            phase  <= PH_BRK;
            c_t    <= '0;
            toff_q <= 1'b0;
          end
        end
        PH_BRK: begin
          if (us_tick && !brk_timeout) c_t <= c_t + 1'b1;
          if (wrq_rise || brk_timeout) begin
            phase  <= PH_IDLE;
            toff_q <= 1'b0;
          end else if (tes_edge) begin
            toff_q <= hfl_lvl;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      jpp_q  <= 1'b0;
      jpm_q  <= 1'b0;
      gain_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      jpp_q  <= (phase == PH_ACC && dir_out) || (phase == PH_DEC && !dir_out);
      jpm_q  <= (phase == PH_ACC && !dir_out) || (phase == PH_DEC && dir_out);
      gain_q <= (phase == PH_BRK);
      busy_q <= (phase != PH_IDLE);
    end
  end

  assign jp_plus    = jpp_q;
  assign jp_minus   = jpm_q;
  assign toff       = toff_q;
  assign gain_boost = gain_q;
  assign busy       = busy_q;

  assert_jp_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
    !(jpp_q && jpm_q));
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    !busy_q |-> (!toff_q && !gain_q && !jpp_q && !jpm_q));
  assert_acc_next_R3: assert property (@(posedge clk) disable iff (rst)
    phase == PH_ACC |=> (phase == PH_ACC || phase == PH_DEC));
  assert_dec_next_R5: assert property (@(posedge clk) disable iff (rst)
    phase == PH_DEC |=> (phase == PH_DEC || phase == PH_BRK));
  assert_brk_next_R8: assert property (@(posedge clk) disable iff (rst)
    phase == PH_BRK |=> (phase == PH_BRK || phase == PH_IDLE));
  assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_IDLE && start_cmd) |=> ($stable(target_q) && $stable(dir_out) && $stable(thr_q)));
endmodule

// File: rtl/trackjump_seq.sv
module trackjump_seq #(
  parameter int N_W      = 8,
  parameter int TIME_W   = 16,
  parameter int HP_W     = 9,
  parameter int BRAKE_US = 60000
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           us_tick,
  input  logic           cmd_valid,
  input  logic [7:0]     cmd_code,
  input  logic [N_W-1:0] cmd_data,
  input  logic           tes_in,
  input  logic           hfl_in,
  input  logic           wrq_in,
  output logic           jp_plus,
  output logic           jp_minus,
  output logic           toff,
  output logic           gain_boost,
  output logic           busy
);
  localparam int SYNC_W = 3;
  localparam int IX_TES = 0;
  localparam int IX_HFL = 1;
  localparam int IX_WRQ = 2;

  logic [SYNC_W-1:0] raw, syn;
  logic [HP_W-1:0]   hp_cnt;

  assign raw = {wrq_in, hfl_in, tes_in};

  tj_sync #(.W(SYNC_W)) u_sync (
    .clk(clk), .rst(rst), .async_i(raw), .sync_o(syn)
  );

  tj_halfper #(.HP_W(HP_W)) u_hp (
    .clk(clk), .rst(rst), .us_tick(us_tick),
    .tes_lvl(syn[IX_TES]), .cnt_o(hp_cnt)
  );

  tj_ctrl #(.N_W(N_W), .TIME_W(TIME_W), .HP_W(HP_W), .BRAKE_US(BRAKE_US)) u_ctrl (
    .clk(clk), .rst(rst), .us_tick(us_tick),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_data(cmd_data),
    .tes_lvl(syn[IX_TES]), .hfl_lvl(syn[IX_HFL]), .wrq_lvl(syn[IX_WRQ]),
    .hp_cnt(hp_cnt),
    .jp_plus(jp_plus), .jp_minus(jp_minus), .toff(toff),
    .gain_boost(gain_boost), .busy(busy)
  );
endmodule

// File: tb/tb_trackjump_seq.sv
module tb_trackjump_seq;
  localparam int CLK_PERIOD = 10;
  localparam int BRAKE = 3000;
  localparam int WD_CYCLES = 150000;
  localparam int NVEC = 6;
  // {mode, code, N, expected target}
  localparam logic [31:0] VEC [NVEC] = '{
    {8'h00, 8'h77, 8'd16,  8'd8},
    {8'h10, 8'h7F, 8'd100, 8'd56},
    {8'h20, 8'h77, 8'd255, 8'd159},
    {8'h30, 8'h7F, 8'd25,  8'd13},
    {8'h10, 8'h77, 8'd23,  8'd13},
    {8'h20, 8'h7F, 8'd17,  8'd11}
  };

  logic clk = 1'b0, rst = 1'b1, us_tick = 1'b1;
  logic cmd_valid = 1'b0;
  logic [7:0] cmd_code = '0, cmd_data = '0;
  logic tes_in = 1'b0, hfl_in = 1'b0, wrq_in = 1'b0;
  logic jp_plus, jp_minus, toff, gain_boost, busy;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trackjump_seq #(.BRAKE_US(BRAKE)) dut (
    .clk(clk), .rst(rst), .us_tick(us_tick),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_data(cmd_data),
    .tes_in(tes_in), .hfl_in(hfl_in), .wrq_in(wrq_in),
    .jp_plus(jp_plus), .jp_minus(jp_minus), .toff(toff),
    .gain_boost(gain_boost), .busy(busy)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] code, input logic [7:0] data);
    cmd_valid = 1'b1; cmd_code = code; cmd_data = data;
    step(1);
    cmd_valid = 1'b0;
  endtask

  task automatic rises(input int n, input int h);
    for (int i = 0; i < n; i++) begin
      tes_in = 1'b0; step(h);
      tes_in = 1'b1; step(h);
    end
  endtask

  task automatic finish_wrq();
    wrq_in = 1'b1; step(6);
    wrq_in = 1'b0; tes_in = 1'b0; hfl_in = 1'b0; step(6);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    step(4);
    rst = 1'b0;
    step(2);
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 jp_plus", jp_plus, 0);
    chk("R1 jp_minus", jp_minus, 0);
    chk("R1 toff", toff, 0);
    chk("R1 gain", gain_boost, 0);

    // table walk: R2 R3 R6 R7 R8
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] md, cd, nn, tg;
      logic outw;
      {md, cd, nn, tg} = VEC[v];
      outw = (cd == 8'h7F);
      send(8'h48, md);
      send(cd, nn);
      step(4);
      chk("R2 busy after start", busy, 1);
      chk("R6 accel plus", jp_plus, outw);
      chk("R6 accel minus", jp_minus, !outw);
      chk("R7 toff in accel", toff, 0);
      rises(int'(tg) - 1, 4);
      step(2);
      chk("R3 still accel before target", outw ? jp_plus : jp_minus, 1);
      rises(1, 4);
      step(4);
      chk("R3 decel plus at target", jp_plus, !outw);
      chk("R3 decel minus at target", jp_minus, outw);
      step(400);
      chk("R7 gain in brake", gain_boost, 1);
      chk("R6 no drive in brake", {31'd0, jp_plus | jp_minus}, 0);
      finish_wrq();
      chk("R8 wrq ends jump", busy, 0);
      chk("R7 gain after end", gain_boost, 0);
    end

    // R2 short count and unknown code ignored
    send(8'h77, 8'd15);
    step(5);
    chk("R2 N=15 ignored", busy, 0);
    send(8'h78, 8'd40);
    step(5);
    chk("R2 unknown code ignored", busy, 0);

    // R4 thresholds: 17, 185, 306
    begin
      int thr [3] = '{17, 185, 306};
      logic [7:0] md [3] = '{8'h01, 8'h0C, 8'h00};
      for (int j = 0; j < 3; j++) begin
        send(8'h48, md[j]);
        send(8'h7F, 8'd16);
        rises(7, 30);
        tes_in = 1'b0; step(30);
        tes_in = 1'b1;
        step(8);
        chk("R4 decel entered", jp_minus, 1);
        step(thr[j] - 10);
        chk("R4 still decel below threshold", jp_minus, 1);
        step(14);
        chk("R4 brake after threshold", gain_boost, 1);
        finish_wrq();
      end
    end

    // R5 guard: TES keeps toggling fast, threshold 306 never reached
    send(8'h48, 8'h00);
    send(8'h77, 8'd16);
    rises(8, 4);
    rises(4, 4);
    chk("R5 decel before guard", jp_plus, 1);
    rises(7, 4);
    chk("R5 guard brake", gain_boost, 1);
    chk("R5 drive off", {31'd0, jp_plus | jp_minus}, 0);
    finish_wrq();
    chk("R8 end after guard", busy, 0);

    // R9 commands while busy
    send(8'h48, 8'h00);
    send(8'h77, 8'd16);
    rises(3, 30);
    send(8'h7F, 8'd255);
    send(8'h48, 8'h01);
    rises(4, 30);
    chk("R9 direction kept", jp_minus, 1);
    tes_in = 1'b0; step(30);
    tes_in = 1'b1;
    step(8);
    chk("R9 target kept", jp_plus, 1);
    step(92);
    chk("R9 threshold kept", jp_plus, 1);
    step(250);
    chk("R9 brake reached", gain_boost, 1);
    finish_wrq();

    // R7 toff capture, R8 timeout
    send(8'h48, 8'h01);
    send(8'h77, 8'd16);
    rises(8, 4);
    step(30);
    chk("R7 brake entered", gain_boost, 1);
    chk("R7 toff low at brake entry", toff, 0);
    hfl_in = 1'b1; tes_in = 1'b0;
    step(6);
    chk("R7 toff takes mirror", toff, 1);
    hfl_in = 1'b0;
    step(6);
    chk("R7 toff held between edges", toff, 1);
    tes_in = 1'b1;
    step(6);
    chk("R7 toff takes data", toff, 0);
    step(BRAKE - 150);
    chk("R8 busy before timeout", busy, 1);
    step(200);
    chk("R8 timeout ends jump", busy, 0);
    tes_in = 1'b0; step(6);

    // same-cycle TES edge and WRQ rise during brake: exit wins
    send(8'h48, 8'h01);
    send(8'h7F, 8'd16);
    rises(8, 4);
    step(30);
    chk("R8 brake before coincidence", gain_boost, 1);
    hfl_in = 1'b1; tes_in = 1'b0; wrq_in = 1'b1;
    step(6);
    chk("R8 coincident exit", busy, 0);
    chk("R7 toff low after coincident exit", toff, 0);
    wrq_in = 1'b0; hfl_in = 1'b0;
    step(4);

    // R1 reset in mid-jump
    send(8'h77, 8'd16);
    step(4);
    rst = 1'b1; step(2); rst = 1'b0; step(2);
    chk("R1 reset clears busy", busy, 0);
    chk("R1 reset clears drive", {31'd0, jp_plus | jp_minus}, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule